// File: doc/BRIEF.md
# Command-Driven Security Status and Lock Register

This block keeps five sticky security flags that software cannot write directly. Each flag moves only when a decoded one-shot command names it: an open or lock command sets it, and a close or unlock command clears it. Two of the flags act as write locks. One lock protects a pair of control registers and the other protects a group of six memory-window and scratch registers. Two more status bits are not stored. They are derived from an 8-bit thread-join bitmap, which join commands build up and join-clear commands tear down, compared against a thread-exists bitmap.

Commands arrive on `N_LANES` parallel lanes. Each lane has a strobe, a 4-bit code and a thread number, and two lanes may name the same flag in one cycle. Each stored flag is a two-state machine with states FLAG_CLEAR and FLAG_SET. SET_CMD moves a flag from FLAG_CLEAR to FLAG_SET when no clear command for it is present. CLEAR_CMD moves a flag from FLAG_SET to FLAG_CLEAR. Every other case holds the current state. The protected registers are written through a simple select/data port. The result is read as a 16-bit status word and a flat bus of register contents.

Command codes: 0 no-op, 1 open-locality, 2 close-locality, 3 config-checked, 4 unlock-memory-config, 5 open-private, 6 close-private, 7 lock-memory-config, 8 lock-base, 9 unlock-base, 10 join, 11 join-clear. Codes 12 to 15 are unknown.

Top module: `sec_status_lock`

## Requirements
- R1: While `rst_n` is low and right after it rises, the status word reads 16'h0002 and every protected register reads 0.
- R2: A set command updates the status word on the clock edge after its strobe. The updates are: code 1 sets bit 14 (locality open), code 3 sets bit 11 (config checked), code 5 sets bit 7 (private open), code 7 sets bit 6 (memory-config lock) and code 8 sets bit 5 (base lock).
- R3: A clear command takes effect on the next edge. Code 2 clears bit 14, code 6 clears bit 7 and code 9 clears bit 5. Code 4 clears both bit 11 and bit 6.
- R4: When a set command and a clear command for the same flag arrive in one cycle, on any lanes, the flag ends up clear.
- R5: While bit 6 is set, writes to register selects 0 and 1 are ignored.
- R6: While bit 5 is set, writes to register selects 2 to 7 are ignored.
- R7: A write to an unlocked register lands on the next edge. A write issued in the same cycle as the lock command for its group still lands, because the lock takes effect one edge later.
- R8: Status bit 1 is 1 exactly when the join bitmap is all zero.
- R9: Status bit 0 is 1 exactly when the join bitmap equals `thread_exists` and is nonzero. Bits 0 and 1 are never both 1.
- R10: Code 10 sets the join bit of the lane's thread and code 11 clears it, both on the next edge. If both arrive for the same thread in one cycle, the bit ends up clear.
- R11: Reserved status bits (15, 13, 12, 10, 9, 8, 4, 3, 2) read 0. Unknown codes 12 to 15 change nothing. A write with select 8 (the status word) or higher changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | N_LANES | One command strobe per lane |
| cmd_code | input | 4*N_LANES | Command code per lane, lane 0 in the low nibble |
| cmd_thread | input | N_LANES*$clog2(N_THR) | Thread number per lane for join and join-clear |
| thread_exists | input | N_THR | Bitmap of threads that exist |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select: 0-1 control pair, 2-7 window/scratch group, 8+ status (ignored) |
| wr_data | input | DATA_W | Write data |
| status_word | output | 16 | Read-only status word |
| prot_q | output | 8*DATA_W | Protected register contents, select i at bits [i*DATA_W +: DATA_W] |

## Verification
Two pairs of functions can coincide in a single cycle. The first pair is a lock command and a write to a register in the group that command protects. The bench issues lock-base on lane 0 alongside a write to select 3 and expects the write to land. It then expects the next write to the same register to be dropped. The second pair is a set and a clear for one flag, or a join and a join-clear for one thread, issued on the two lanes together. The bench judges these from the status word one edge later, expecting the clear to have won.

// File: rtl/sec_status_pkg.sv
package sec_status_pkg;

    localparam int CMD_W  = 4;
    localparam int SEL_W  = 4;
    localparam int STAT_W = 16;
    localparam int N_REG  = 8;
    localparam int N_CFG  = 2;   // selects below this belong to the memory-config lock group
    localparam int N_FLAG = 5;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP         = 4'd0,
        CMD_OPEN_LOC    = 4'd1,
        CMD_CLOSE_LOC   = 4'd2,
        CMD_CFG_OK      = 4'd3,
        CMD_UNLOCK_MCFG = 4'd4,
        CMD_OPEN_PRIV   = 4'd5,
        CMD_CLOSE_PRIV  = 4'd6,
        CMD_LOCK_MCFG   = 4'd7,
        CMD_LOCK_BASE   = 4'd8,
        CMD_UNLOCK_BASE = 4'd9,
        CMD_JOIN        = 4'd10,
        CMD_JOIN_CLR    = 4'd11
    } cmd_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

    // stored flag indices
    localparam int FLG_LOC   = 0;
    localparam int FLG_CFGOK = 1;
    localparam int FLG_PRIV  = 2;
    localparam int FLG_MLOCK = 3;
    localparam int FLG_BLOCK = 4;

    // status word bit positions
    localparam int ST_LOC   = 14;
    localparam int ST_CFGOK = 11;
    localparam int ST_PRIV  = 7;
    localparam int ST_MLOCK = 6;
    localparam int ST_BLOCK = 5;
    localparam int ST_EXIT  = 1;
    localparam int ST_ENTER = 0;

endpackage

// File: rtl/sec_cmd_decode.sv
module sec_cmd_decode
    import sec_status_pkg::*;
#(
    parameter int N_LANES = 2,
    parameter int N_THR   = 8,
    localparam int THR_W  = $clog2(N_THR)
) (
    input  logic [N_LANES-1:0]       valid_i,
    input  logic [N_LANES*CMD_W-1:0] code_i,
    input  logic [N_LANES*THR_W-1:0] thread_i,
    output logic [N_FLAG-1:0]        set_o,
    output logic [N_FLAG-1:0]        clr_o,
    output logic [N_THR-1:0]         join_set_o,
    output logic [N_THR-1:0]         join_clr_o
);

    always_comb begin
        set_o      = '0;
        clr_o      = '0;
        join_set_o = '0;
        join_clr_o = '0;
        for (int l = 0; l < N_LANES; l++) begin
            if (valid_i[l]) begin
                case (cmd_e'(code_i[l*CMD_W +: CMD_W]))
                    CMD_OPEN_LOC:    set_o[FLG_LOC]   = 1'b1;
                    CMD_CLOSE_LOC:   clr_o[FLG_LOC]   = 1'b1;
                    CMD_CFG_OK:      set_o[FLG_CFGOK] = 1'b1;
                    CMD_UNLOCK_MCFG: begin
                        clr_o[FLG_CFGOK] = 1'b1;
                        clr_o[FLG_MLOCK] = 1'b1;
                    end
                    CMD_OPEN_PRIV:   set_o[FLG_PRIV]  = 1'b1;
                    CMD_CLOSE_PRIV:  clr_o[FLG_PRIV]  = 1'b1;
                    CMD_LOCK_MCFG:   set_o[FLG_MLOCK] = 1'b1;
                    CMD_LOCK_BASE:   set_o[FLG_BLOCK] = 1'b1;
                    CMD_UNLOCK_BASE: clr_o[FLG_BLOCK] = 1'b1;
                    CMD_JOIN:        join_set_o[thread_i[l*THR_W +: THR_W]] = 1'b1;
                    CMD_JOIN_CLR:    join_clr_o[thread_i[l*THR_W +: THR_W]] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sec_flag_fsm.sv
module sec_flag_fsm
    import sec_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_i && !clr_i) state_d = FLAG_SET;   // SET_CMD
            FLAG_SET:   if (clr_i)           state_d = FLAG_CLEAR; // CLEAR_CMD
        endcase
    end

    always_comb begin
        q_o = (state_q == FLAG_SET);
    end

endmodule

// File: rtl/sec_join_tracker.sv
module sec_join_tracker #(
    parameter int N_THR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_THR-1:0] set_i,
    input  logic [N_THR-1:0] clr_i,
    input  logic [N_THR-1:0] exists_i,
    output logic             exit_done_o,
    output logic             enter_done_o
);

    logic [N_THR-1:0] join_q;

    always_ff @(posedge clk) begin
        if (!rst_n) join_q <= '0;
        else        join_q <= (join_q | set_i) & ~clr_i;
    end

    always_comb begin
        exit_done_o  = (join_q == '0);
        enter_done_o = (join_q == exists_i) && (join_q != '0);
    end

endmodule

// File: rtl/sec_prot_regs.sv
module sec_prot_regs
    import sec_status_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    cfg_lock,
    input  logic                    base_lock,
    output logic [N_REG*DATA_W-1:0] q_o
);

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        logic locked;
        logic [DATA_W-1:0] r_q;

        if (i < N_CFG) begin : g_cfg
            assign locked = cfg_lock;
        end else begin : g_base
            assign locked = base_lock;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q <= '0;
            else if (wr_en && wr_sel == SEL_W'(i) && !locked)
                r_q <= wr_data;
        end

        assign q_o[i*DATA_W +: DATA_W] = r_q;
    end

endmodule

// File: rtl/sec_status_lock.sv
module sec_status_lock
    import sec_status_pkg::*;
#(
    parameter int N_LANES = 2,
    parameter int N_THR   = 8,
    parameter int DATA_W  = 32,
    localparam int THR_W  = $clog2(N_THR)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_LANES-1:0]            cmd_valid,
    input  logic [N_LANES*CMD_W-1:0]      cmd_code,
    input  logic [N_LANES*THR_W-1:0]      cmd_thread,
    input  logic [N_THR-1:0]              thread_exists,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [STAT_W-1:0]             status_word,
    output logic [N_REG*DATA_W-1:0]       prot_q
);

    logic [N_FLAG-1:0] flag_set, flag_clr, flag_q;
    logic [N_THR-1:0]  join_set, join_clr;
    logic              exit_done, enter_done;

    sec_cmd_decode #(.N_LANES(N_LANES), .N_THR(N_THR)) u_decode (
        .valid_i    (cmd_valid),
        .code_i     (cmd_code),
        .thread_i   (cmd_thread),
        .set_o      (flag_set),
        .clr_o      (flag_clr),
        .join_set_o (join_set),
        .join_clr_o (join_clr)
    );

    for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
        sec_flag_fsm u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[f]),
            .clr_i (flag_clr[f]),
            .q_o   (flag_q[f])
        );
    end

    sec_join_tracker #(.N_THR(N_THR)) u_join (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (join_set),
        .clr_i        (join_clr),
        .exists_i     (thread_exists),
        .exit_done_o  (exit_done),
        .enter_done_o (enter_done)
    );

    sec_prot_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cfg_lock  (flag_q[FLG_MLOCK]),
        .base_lock (flag_q[FLG_BLOCK]),
        .q_o       (prot_q)
    );

    always_comb begin
        status_word           = '0;
        status_word[ST_LOC]   = flag_q[FLG_LOC];
        status_word[ST_CFGOK] = flag_q[FLG_CFGOK];
        status_word[ST_PRIV]  = flag_q[FLG_PRIV];
        status_word[ST_MLOCK] = flag_q[FLG_MLOCK];
        status_word[ST_BLOCK] = flag_q[FLG_BLOCK];
        status_word[ST_EXIT]  = exit_done;
        status_word[ST_ENTER] = enter_done;
    end

endmodule

// File: rtl/sec_status_lock_chk.sv
module sec_status_lock_chk
    import sec_status_pkg::*;
#(
    parameter int N_LANES = 2,
    parameter int DATA_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_LANES-1:0]      cmd_valid,
    input logic [N_LANES*CMD_W-1:0] cmd_code,
    input logic                    wr_en,
    input logic [SEL_W-1:0]        wr_sel,
    input logic [STAT_W-1:0]       status_word,
    input logic [N_REG*DATA_W-1:0] prot_q
);

    logic seen_open_loc, seen_close_loc, seen_unlock_mcfg, any_cmd;

    always_comb begin
        seen_open_loc    = 1'b0;
        seen_close_loc   = 1'b0;
        seen_unlock_mcfg = 1'b0;
        any_cmd          = |cmd_valid;
        for (int l = 0; l < N_LANES; l++) begin
            if (cmd_valid[l] && cmd_code[l*CMD_W +: CMD_W] == 4'd1) seen_open_loc    = 1'b1;
            if (cmd_valid[l] && cmd_code[l*CMD_W +: CMD_W] == 4'd2) seen_close_loc   = 1'b1;
            if (cmd_valid[l] && cmd_code[l*CMD_W +: CMD_W] == 4'd4) seen_unlock_mcfg = 1'b1;
        end
    end

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & 16'hB71C) == 16'h0000);

    assert_done_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_word[ST_ENTER] && status_word[ST_EXIT]));

    assert_open_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_open_loc && !seen_close_loc) |=> status_word[ST_LOC]);

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_close_loc |=> !status_word[ST_LOC]);

    assert_unlock_mcfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_unlock_mcfg |=> (!status_word[ST_CFGOK] && !status_word[ST_MLOCK]));

    assert_cfg_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[ST_MLOCK] && wr_en && wr_sel < SEL_W'(N_CFG)) |=> $stable(prot_q));

    assert_base_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[ST_BLOCK] && wr_en && wr_sel >= SEL_W'(N_CFG) && wr_sel < SEL_W'(N_REG))
        |=> $stable(prot_q));

    assert_status_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel >= SEL_W'(N_REG)) |=> $stable(prot_q));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_cmd |=> $stable(status_word[15:1]));

endmodule

bind sec_status_lock sec_status_lock_chk #(.N_LANES(N_LANES), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .status_word (status_word),
    .prot_q      (prot_q)
);

// File: tb/sec_status_lock_tb.sv
module sec_status_lock_tb;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cmd_valid;
    logic [7:0]    cmd_code;
    logic [5:0]    cmd_thread;
    logic [7:0]    thread_exists;
    logic          wr_en;
    logic [3:0]    wr_sel;
    logic [DW-1:0] wr_data;
    logic [15:0]   status_word;
    logic [8*DW-1:0] prot_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sec_status_lock #(.N_LANES(2), .N_THR(8), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_thread(cmd_thread), .thread_exists(thread_exists), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .status_word(status_word), .prot_q(prot_q)
    );

    // entry: [31:24] lane0 {valid,code[3:0],thread[2:0]}, [23:16] lane1, [15:0] expected status
    localparam logic [31:0] VEC [0:14] = '{
        {8'h88, 8'h00, 16'h4002},  // R2 open locality
        {8'h98, 8'hA8, 16'h4882},  // R2 config checked + open private
        {8'hB8, 8'hC0, 16'h48E2},  // R2 lock mem-config + lock base
        {8'hE8, 8'h00, 16'h48E2},  // R11 unknown code 13
        {8'hD0, 8'h00, 16'h48E0},  // R10 join thread 0
        {8'hD1, 8'h00, 16'h48E1},  // R9 join thread 1 -> equals exists
        {8'h88, 8'h90, 16'h08E1},  // R4 open + close locality
        {8'hD8, 8'h00, 16'h08E0},  // R10 join-clear thread 0
        {8'hD0, 8'hD8, 16'h08E0},  // R10 join + join-clear thread 0
        {8'hA0, 8'h00, 16'h00A0},  // R3 unlock mem-config clears two flags
        {8'hB0, 8'hC8, 16'h0000},  // R3 close private + unlock base
        {8'hD9, 8'h00, 16'h0002},  // R8 last join bit cleared
        {8'hB8, 8'hA0, 16'h0002},  // R4 lock + unlock mem-config
        {8'hD2, 8'h00, 16'h0000},  // R9 join a thread not in exists
        {8'hDA, 8'h00, 16'h0002}   // R8 cleared again
    };

    function automatic string vec_req(int i);
        case (i)
            0, 1, 2:   return "R2";
            3:         return "R11";
            4, 7, 8:   return "R10";
            5, 13:     return "R9";
            6, 12:     return "R4";
            9, 10:     return "R3";
            default:   return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = '0; cmd_code = '0; cmd_thread = '0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic lane0(input logic [3:0] code, input logic [2:0] thr);
        cmd_valid[0] = 1'b1; cmd_code[3:0] = code; cmd_thread[2:0] = thr;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
    endtask

    task automatic step();  // one edge, then sample at the following negedge
        @(negedge clk);
        idle();
    endtask

    function automatic logic [31:0] reg_q(int i);
        return prot_q[i*DW +: DW];
    endfunction

    initial begin
        idle();
        thread_exists = 8'h03;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "status in reset", {16'h0, status_word}, 32'h0002);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "status after reset", {16'h0, status_word}, 32'h0002);
        check("R1", "regs after reset", {31'h0, |prot_q}, 32'h0);

        for (int i = 0; i < 15; i++) begin
            cmd_valid  = {VEC[i][23], VEC[i][31]};
            cmd_code   = {VEC[i][22:19], VEC[i][30:27]};
            cmd_thread = {VEC[i][18:16], VEC[i][26:24]};
            step();
            check(vec_req(i), $sformatf("vector %0d status", i), {16'h0, status_word}, {16'h0, VEC[i][15:0]});
        end

        // R7: unlocked writes land
        wr(4'd0, 32'hA5A50000); step();
        check("R7", "reg0 unlocked write", reg_q(0), 32'hA5A50000);

        // R5: mem-config lock blocks selects 0/1, not the other group
        lane0(4'd7, 3'd0); step();
        wr(4'd0, 32'h11111111); step();
        check("R5", "reg0 locked write", reg_q(0), 32'hA5A50000);
        wr(4'd1, 32'h12121212); step();
        check("R5", "reg1 locked write", reg_q(1), 32'h0);
        wr(4'd2, 32'h22222222); step();
        check("R7", "reg2 other group write", reg_q(2), 32'h22222222);

        // R7: write in same cycle as lock-base lands
        lane0(4'd8, 3'd0); wr(4'd3, 32'h33333333); step();
        check("R7", "reg3 same-cycle lock", reg_q(3), 32'h33333333);
        check("R2", "base lock status", {16'h0, status_word}, 32'h0062);

        // R6: base lock blocks selects 2..7
        wr(4'd3, 32'h44444444); step();
        check("R6", "reg3 locked write", reg_q(3), 32'h33333333);
        wr(4'd7, 32'h77777777); step();
        check("R6", "reg7 locked write", reg_q(7), 32'h0);

        // R11: status-word write has no effect
        wr(4'd8, 32'hFFFFFFFF); step();
        check("R11", "status after status write", {16'h0, status_word}, 32'h0062);
        check("R11", "reg0 after status write", reg_q(0), 32'hA5A50000);

        // R9: enter-done follows the exists bitmap
        thread_exists = 8'h01;
        lane0(4'd10, 3'd0); step();
        check("R9", "enter done set", {16'h0, status_word}, 32'h0061);
        thread_exists = 8'h03;
        #1;
        check("R9", "enter done drops", {16'h0, status_word}, 32'h0060);

        // R3: unlock-base reopens the group
        lane0(4'd9, 3'd0); step();
        wr(4'd7, 32'h77777777); step();
        check("R3", "reg7 after unlock", reg_q(7), 32'h77777777);

        // R1: reset clears everything again
        rst_n = 1'b0; step();
        check("R1", "status on re-reset", {16'h0, status_word}, 32'h0002);
        check("R1", "regs on re-reset", {31'h0, |prot_q}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule